// File: doc/BRIEF.md
# Idle-Timed Memory Low-Power Controller

This block sits beside a DRAM controller and watches its request stream. Once the memory interface has seen no request for a programmable number of memory-clock cycles, it asks for the external memory to be put into one of two low-power states: clock stop or self refresh. A two-bit mode input selects which state is used, or turns the feature off. Each state has its own 4-bit idle code. Code 0 means "enter on the first idle cycle". A nonzero code n means 2^(n+3) idle cycles.

The programmed codes are not used directly. The block keeps an active copy of each code and refreshes both copies only when a read request is accepted. After software rewrites a code, a dummy read is therefore needed before the new value applies. Any request that arrives while the memory is in a low-power state is stalled. The block then raises an exit request and waits for an exit-done handshake before letting traffic through. A change of mode while in a low-power state also forces an exit.

Top module: `mem_lp_ctrl`

## Requirements
- R1: After reset, all enter and exit pulses, the stall output and the low-power flag are 0. Both active codes are 0.
- R2: With an active code of 0, the enter pulse is high in the cycle after the first idle cycle that is counted under a stable enabled mode.
- R3: With an active code n of 1 to 15, the enter pulse appears 2^(n+3)+1 cycles after counting starts. That is, 2^(n+3) complete idle cycles are seen, and the pulse is registered on the next idle cycle.
- R4: Mode 2 uses the self-refresh code and pulses sr_enter. Mode 1 uses the clock-stop code and pulses cs_enter. The enter and exit outputs are never high together.
- R5: Modes 0 and 3 never produce an enter pulse, and they hold the idle count at zero.
- R6: A new value on cs_code or sr_code takes effect only when a read request (req_valid=1, req_read=1) is accepted. A write request does not load it.
- R7: Any request, read or write, seen while the block is running restarts the idle count from zero.
- R8: A request seen in a low-power state is stalled (req_stall=1), and the exit pulse for that state is issued on the next cycle. The stall stays high until exit_done is sampled high, after which the block returns to the running state.
- R9: A change of lp_mode in a low-power state issues the matching exit pulse. A mode change while running restarts the idle count.
- R10: While in a low-power state, no further enter pulse is produced, however long the interface stays idle.
- R11: in_lp is high from the cycle of the enter pulse until the cycle after exit_done is sampled in the exiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_read | input | 1 | The presented request is a read |
| lp_mode | input | 2 | 0/3 off, 1 clock stop, 2 self refresh |
| cs_code | input | 4 | Programmed clock-stop idle code |
| sr_code | input | 4 | Programmed self-refresh idle code |
| exit_done | input | 1 | Memory has left the low-power state |
| req_stall | output | 1 | Presented request must wait |
| cs_enter | output | 1 | One-cycle pulse: enter clock stop |
| cs_exit | output | 1 | One-cycle pulse: leave clock stop |
| sr_enter | output | 1 | One-cycle pulse: enter self refresh |
| sr_exit | output | 1 | One-cycle pulse: leave self refresh |
| in_lp | output | 1 | Memory is in, or is leaving, a low-power state |

## Verification
The hardest case to reach is a stale active code. Software has rewritten a code and a write has gone through, but no read has yet refreshed the active copy. This can only be seen in the entry delay. The stimulus first changes sr_code and exits with a write, and checks that the old 16-cycle delay still holds. It then exits with a read and checks for the new 64-cycle delay. Long random runs with small codes and rare requests also check mode flips and exit handshakes against a cycle model.

// File: rtl/mem_lp_ctrl.sv
module mem_lp_ctrl #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [1:0]        lp_mode,
  input  logic [CODE_W-1:0] cs_code,
  input  logic [CODE_W-1:0] sr_code,
  input  logic              exit_done,
  output logic              req_stall,
  output logic              cs_enter,
  output logic              cs_exit,
  output logic              sr_enter,
  output logic              sr_exit,
  output logic              in_lp
);
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_CS = 2'd1, ST_SR = 2'd2, ST_EXIT = 2'd3} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt, thr;
  logic [CODE_W-1:0] act_cs, act_sr, sel_code;
  logic [1:0]        mode_q;
  logic              lp_on, load, restart;

  assign lp_on     = (lp_mode == 2'd1) || (lp_mode == 2'd2);
  assign in_lp     = (st != ST_RUN);
  assign req_stall = req_valid && in_lp;
  assign load      = req_valid && req_read && !req_stall;
  assign restart   = !lp_on || req_valid || (lp_mode != mode_q);
  assign sel_code  = (lp_mode == 2'd2) ? act_sr : act_cs;
  assign thr       = (sel_code == '0) ? '0
                   : ({{(CNT_W-1){1'b0}}, 1'b1} << (32'(sel_code) + 32'd3));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      cnt      <= '0;
      act_cs   <= '0;
      act_sr   <= '0;
      mode_q   <= 2'd0;
      cs_enter <= 1'b0;
      sr_enter <= 1'b0;
      cs_exit  <= 1'b0;
      sr_exit  <= 1'b0;
    end else begin
      cs_enter <= 1'b0;
      sr_enter <= 1'b0;
      cs_exit  <= 1'b0;
      sr_exit  <= 1'b0;
      mode_q   <= lp_mode;
      if (load) begin
        act_cs <= cs_code;
        act_sr <= sr_code;
      end
      case (st)
        ST_RUN: begin
          if (restart) cnt <= '0;
          else if (cnt >= thr) begin
            cnt      <= '0;
            st       <= st_t'(lp_mode);
            sr_enter <= (lp_mode == 2'd2);
            cs_enter <= (lp_mode == 2'd1);
          end else cnt <= cnt + 1'b1;
        end
        ST_CS, ST_SR: begin
          if (req_valid || (lp_mode != 2'(st))) begin
            st      <= ST_EXIT;
            sr_exit <= (st == ST_SR);
            cs_exit <= (st == ST_CS);
          end
        end
        default: if (exit_done) st <= ST_RUN;
      endcase
    end
  end

  p_pulse_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_enter, sr_enter, cs_exit, sr_exit}));
  p_sr_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |-> $past(lp_mode) == 2'd2);
  p_cs_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_enter |-> $past(lp_mode) == 2'd1);
  p_off_modes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_on |=> !(cs_enter || sr_enter));
  p_exit_on_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CS || st == ST_SR) && req_valid |=> (cs_exit || sr_exit));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXIT) && exit_done |=> !in_lp);
  p_no_reenter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_lp) |-> !(cs_enter || sr_enter));
endmodule

// File: tb/mem_lp_ctrl_test.sv
`timescale 1ns/1ps
module mem_lp_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, req_valid = 1'b0, req_read = 1'b0, exit_done = 1'b1;
  logic [1:0] lp_mode = 2'd0;
  logic [3:0] cs_code = 4'd0, sr_code = 4'd0;
  logic req_stall, cs_enter, cs_exit, sr_enter, sr_exit, in_lp;

  int tests = 0, fails = 0, n = 0, cnt_en = 0;
  int m_st = 0, m_cnt = 0, m_mprev = 0, m_acs = 0, m_asr = 0;
  bit m_cse, m_sre, m_csx, m_srx;
  bit saw_sr;

  always #2 clk = ~clk;

  mem_lp_ctrl uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .lp_mode(lp_mode), .cs_code(cs_code), .sr_code(sr_code), .exit_done(exit_done),
    .req_stall(req_stall), .cs_enter(cs_enter), .cs_exit(cs_exit), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .in_lp(in_lp));

  function automatic int thr_of(int code);
    return (code == 0) ? 0 : (1 << (code + 3));
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit stall;
    int m;
    stall = req_valid && (m_st != 0);
    m = int'(lp_mode);
    {m_cse, m_sre, m_csx, m_srx} = 4'b0;
    case (m_st)
      0: begin
        if (!(m == 1 || m == 2) || req_valid || m != m_mprev) m_cnt = 0;
        else if (m_cnt >= thr_of(m == 2 ? m_asr : m_acs)) begin
          m_cnt = 0; m_st = m; m_sre = (m == 2); m_cse = (m == 1);
        end else m_cnt++;
      end
      1, 2: if (req_valid || m != m_st) begin
        m_srx = (m_st == 2); m_csx = (m_st == 1); m_st = 3;
      end
      default: if (exit_done) m_st = 0;
    endcase
    if (req_valid && req_read && !stall) begin
      m_acs = int'(cs_code); m_asr = int'(sr_code);
    end
    m_mprev = m;
  endtask

  task automatic step();
    @(posedge clk);
    #1 model_update();
    @(negedge clk);
    chk("R3 cs_enter", int'(cs_enter), int'(m_cse));
    chk("R3 sr_enter", int'(sr_enter), int'(m_sre));
    chk("R8 cs_exit", int'(cs_exit), int'(m_csx));
    chk("R8 sr_exit", int'(sr_exit), int'(m_srx));
    chk("R8 req_stall", int'(req_stall), int'(req_valid && m_st != 0));
    chk("R11 in_lp", int'(in_lp), int'(m_st != 0));
    if (cs_enter || sr_enter) cnt_en++;
  endtask

  task automatic wait_enter(input int maxn, output int k);
    k = 0;
    repeat (maxn) begin
      step(); k++;
      if (cs_enter || sr_enter) begin
        saw_sr = sr_enter;
        return;
      end
    end
    k = -1;
  endtask

  task automatic do_req(bit rd);
    req_valid = 1'b1; req_read = rd;
    #1 chk("R8 stall in lp", int'(req_stall), 1);
    step();
    chk("R8 exit pulse", int'(cs_exit || sr_exit), 1);
    step();
    step();
    chk("R8 released", int'(req_stall), 0);
    req_valid = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    lp_mode = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 in_lp", int'(in_lp), 0);
    chk("R1 pulses", int'({cs_enter, sr_enter, cs_exit, sr_exit}), 0);
    chk("R1 stall", int'(req_stall), 0);
    step();
    wait_enter(10, n);
    chk("R2 code0 delay", n, 1);
    chk("R4 self refresh kind", int'(saw_sr), 1);
    cnt_en = 0;
    repeat (300) step();
    chk("R10 no reentry", cnt_en, 0);
    sr_code = 4'd1;
    do_req(1'b1);
    wait_enter(100, n);
    chk("R3 code1 delay", n, 17);
    sr_code = 4'd3;
    do_req(1'b0);
    wait_enter(100, n);
    chk("R6 write keeps old code", n, 17);
    do_req(1'b1);
    wait_enter(200, n);
    chk("R6 read loads code", n, 65);
    sr_code = 4'd1;
    do_req(1'b1);
    repeat (10) step();
    req_valid = 1'b1; req_read = 1'b0;
    step();
    req_valid = 1'b0;
    wait_enter(100, n);
    chk("R7 request restarts count", n, 17);
    lp_mode = 2'd1;
    step();
    chk("R9 mode change exit", int'(sr_exit), 1);
    step();
    wait_enter(10, n);
    chk("R4 clock stop delay", n, 1);
    chk("R4 clock stop kind", int'(saw_sr), 0);
    lp_mode = 2'd0;
    step();
    chk("R9 cs exit on mode", int'(cs_exit), 1);
    cnt_en = 0;
    repeat (300) step();
    lp_mode = 2'd3;
    repeat (100) step();
    chk("R5 off modes no entry", cnt_en, 0);
    chk("R5 not in lp", int'(in_lp), 0);
    for (int i = 0; i < 6000; i++) begin
      req_valid = ($urandom % 30) == 0;
      req_read  = $urandom % 2;
      exit_done = ($urandom % 3) == 0;
      if ($urandom % 150 == 0) lp_mode = 2'($urandom % 4);
      if ($urandom % 80 == 0) cs_code = 4'($urandom % 3);
      if ($urandom % 80 == 0) sr_code = 4'($urandom % 3);
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule